// File: doc/BRIEF.md
# Bitstream-Steered Gain Tap

This block scales a one-bit modulator stream into a sample path without a multiplier. On every accepted sample it either adds a stored signed coefficient to the incoming interpolated sample or subtracts the coefficient from it. The choice is made by the single bit that arrives with the sample. The result is clamped to the signed range and registered. The coefficient is a 16-bit two's-complement value with a full scale of 1.0: 0x8000 is -1.0, 0xC000 is -0.5, 0x0000 is zero, 0x4000 is +0.5 and 0x7FFF is just under +1.0.

Software loads the coefficient one byte at a time through a small write port and stages each byte. Writing the low byte arms the staged word. The armed word becomes the active coefficient at the next accepted sample. A partly written coefficient therefore never reaches the arithmetic.

Top module: `gain_tap`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_sample` go to 0, the active coefficient goes to zero and any armed word is dropped. The first sample after reset therefore passes through unchanged.
- R2: `out_valid` in a cycle equals `in_valid` in the previous cycle, which gives one cycle of latency.
- R3: When `in_valid` is high and `in_bit` is 1, the next `out_sample` is `in_sample` plus the active coefficient.
- R4: When `in_valid` is high and `in_bit` is 0, the next `out_sample` is `in_sample` minus the active coefficient.
- R5: A result above +32767 is output as 0x7FFF.
- R6: A result below -32768 is output as 0x8000.
- R7: A write with `cfg_we` high stores `cfg_byte` as the coefficient's high byte (bits 15:8) when `cfg_sel` is 0, and as its low byte (bits 7:0) when `cfg_sel` is 1.
- R8: A low-byte write arms the staged word. At the next accepted sample the armed word becomes active. That sample still uses the old coefficient, and later samples use the new one. The commit takes the staged word as it stood before that edge. A low-byte write in the same cycle as an accepted sample stays armed for the following sample.
- R9: A high-byte write alone never changes the active coefficient, however many samples follow it.
- R10: While `in_valid` is low, `out_sample` holds its value and the active coefficient does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Coefficient byte write strobe |
| cfg_sel | input | 1 | Byte lane: 0 high byte, 1 low byte (arms commit) |
| cfg_byte | input | 8 | Coefficient byte data |
| in_valid | input | 1 | Sample present; also the commit boundary |
| in_sample | input | 16 | Signed interpolated sample |
| in_bit | input | 1 | Modulator bit: 1 adds, 0 subtracts |
| out_valid | output | 1 | Result present |
| out_sample | output | 16 | Saturated signed result |

## Verification
The hardest situation to reach from the ports is the commit boundary itself. Three cases meet there: a sample that must still see the old coefficient while the new one loads, a high-byte write left without its low byte, and a low-byte write that lands in the same cycle as an accepted sample. The stimulus reaches the first case for every table vector by sending a zero sample with an add bit right after each load, so the output shows the coefficient being replaced. Directed sequences then write only a high byte, and they overlap a low-byte write with a sample.

// File: rtl/gain_tap_pkg.sv
// Package: shared arithmetic helpers for the gain tap.
// Assumes two's-complement operands of equal width.
package gain_tap_pkg;

    // Clamp a result one bit wider than W back into W bits.
    function automatic logic [15:0] clamp16(input logic [16:0] wide);
        logic [15:0] r;
        if (wide[16] != wide[15])
            r = wide[16] ? 16'h8000 : 16'h7FFF;
        else
            r = wide[15:0];
        return r;
    endfunction

endpackage

// File: rtl/gain_tap_coef_bank.sv
// gain_tap_coef_bank: stages coefficient bytes and commits the whole word
// at a sample boundary once the last (lowest) lane has been written.
// Assumes lane 0 is the most significant byte, and that the commit copies
// the staged word as it stood before the clock edge.
module gain_tap_coef_bank #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int COEF_W = BYTE_W * LANES,
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              boundary,
    output logic [COEF_W-1:0] coef_active
);
    localparam logic [SEL_W-1:0] LAST_LANE = SEL_W'(LANES - 1);

    logic [COEF_W-1:0] staged;
    logic              armed;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            // Store one byte lane of the staged word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    staged[COEF_W-1-k*BYTE_W -: BYTE_W] <= '0;
                else if (wr_en && wr_sel == SEL_W'(k))
                    staged[COEF_W-1-k*BYTE_W -: BYTE_W] <= wr_byte;
            end
        end
    endgenerate

    // Arm a commit on the last-lane write; clear it when a boundary consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (wr_en && wr_sel == LAST_LANE)
            armed <= 1'b1;
        else if (boundary)
            armed <= 1'b0;
    end

    // Load the active coefficient at an armed boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            coef_active <= '0;
        else if (boundary && armed)
            coef_active <= staged;
    end
endmodule

// File: rtl/gain_tap_addsub.sv
// gain_tap_addsub: combinational add or subtract of the coefficient, steered
// by one bit, with saturation to the signed 16-bit range.
// Assumes 16-bit two's-complement sample and coefficient.
module gain_tap_addsub
    import gain_tap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] coef,
    input  logic         add_n_sub,
    output logic [W-1:0] result
);
    logic [W:0] sx, cx, wide;

    // Sign-extend, combine by the steering bit, then clamp.
    always_comb begin
        sx   = {sample[W-1], sample};
        cx   = {coef[W-1], coef};
        wide = add_n_sub ? (sx + cx) : (sx - cx);
        result = clamp16(wide);
    end
endmodule

// File: rtl/gain_tap.sv
// gain_tap: top level. Combines the byte-loaded coefficient with each valid
// sample under control of the modulator bit and registers the result.
// Assumes in_valid marks both a sample and a coefficient commit boundary.
module gain_tap #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_byte,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              in_bit,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    logic [DATA_W-1:0] coef_q;
    logic [DATA_W-1:0] sum_c;

    gain_tap_coef_bank #(.BYTE_W(BYTE_W), .LANES(LANES)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_sel      (cfg_sel),
        .wr_byte     (cfg_byte),
        .boundary    (in_valid),
        .coef_active (coef_q)
    );

    gain_tap_addsub #(.W(DATA_W)) u_arith (
        .sample    (in_sample),
        .coef      (coef_q),
        .add_n_sub (in_bit),
        .result    (sum_c)
    );

    // Register the valid flag with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Register the result on accepted samples; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_sample <= '0;
        else if (in_valid) out_sample <= sum_c;
    end
endmodule

// File: rtl/gain_tap_chk.sv
// gain_tap_chk: temporal checks on the gain tap, bound to every instance.
module gain_tap_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_sample,
    input logic         in_bit,
    input logic         out_valid,
    input logic [W-1:0] out_sample,
    input logic [W-1:0] coef_q
);
    // R1: reset clears the outputs and the coefficient
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sample == '0 && coef_q == '0));

    // R2: valid follows with one cycle of latency
    p_valid_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: adding a non-negative coefficient to a non-negative sample never wraps negative
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_bit && !in_sample[W-1] && !coef_q[W-1]) |=> !out_sample[W-1]);

    // R6: subtracting a non-negative coefficient from a negative sample stays negative
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_bit && in_sample[W-1] && !coef_q[W-1]) |=> out_sample[W-1]);

    // R10: idle cycles hold the output and the coefficient
    p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));
    p_hold_coef_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(coef_q));
endmodule

bind gain_tap gain_tap_chk #(.W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .in_bit     (in_bit),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .coef_q     (coef_q)
);

// File: tb/gain_tap_tb.sv
module gain_tap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_byte = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        in_bit = 1'b0;
    logic        out_valid;
    logic [15:0] out_sample;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gain_tap dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_byte(cfg_byte), .in_valid(in_valid), .in_sample(in_sample),
        .in_bit(in_bit), .out_valid(out_valid), .out_sample(out_sample)
    );

    // {coef, sample, bit, expected}
    localparam logic [48:0] VEC [10] = '{
        {16'h4000, 16'h1000, 1'b1, 16'h5000},
        {16'h4000, 16'h1000, 1'b0, 16'hD000},
        {16'hE000, 16'h2000, 1'b1, 16'h0000},
        {16'h7FFF, 16'h7000, 1'b1, 16'h7FFF},
        {16'h8000, 16'h0001, 1'b0, 16'h7FFF},
        {16'h8000, 16'h8000, 1'b1, 16'h8000},
        {16'h2000, 16'h9000, 1'b0, 16'h8000},
        {16'h0000, 16'h1234, 1'b0, 16'h1234},
        {16'hC000, 16'h3000, 1'b0, 16'h7000},
        {16'hA000, 16'h0000, 1'b1, 16'hA000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_byte = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] s, input logic b, output logic [15:0] r);
        @(negedge clk);
        in_valid = 1'b1; in_sample = s; in_bit = b;
        @(negedge clk);
        in_valid = 1'b0;
        r = out_sample;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [15:0] prev_coef;
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", {15'd0, out_valid}, 16'h0000);
        check("R1 reset out_sample", out_sample, 16'h0000);
        rst_n = 1'b1;
        send(16'h0123, 1'b1, r);
        check("R1 zero coef passthrough", r, 16'h0123);
        prev_coef = 16'h0000;

        for (int i = 0; i < 10; i++) begin
            wr(1'b0, VEC[i][48:41]);                    // R7 high byte
            wr(1'b1, VEC[i][40:33]);                    // R7 low byte arms
            send(16'h0000, 1'b1, r);                    // R8 boundary uses old
            check("R8 old coef at commit", r, prev_coef);
            send(VEC[i][32:17], VEC[i][16], r);         // R3 R4 R5 R6 R7
            check("R3/R4/R5/R6/R7 vector", r, VEC[i][15:0]);
            prev_coef = VEC[i][48:33];
        end

        // R2: valid timing
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'h0000; in_bit = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid after sample", {15'd0, out_valid}, 16'h0001);
        r = out_sample;
        @(negedge clk);
        check("R2 valid drops", {15'd0, out_valid}, 16'h0000);
        repeat (3) @(negedge clk);
        check("R10 hold while idle", out_sample, r);

        // R9: high byte alone does nothing
        wr(1'b0, 8'h12);
        send(16'h0000, 1'b1, r);
        check("R9 high only first", r, 16'hA000);
        send(16'h0000, 1'b1, r);
        check("R9 high only second", r, 16'hA000);
        wr(1'b1, 8'h34);
        send(16'h0000, 1'b1, r);
        check("R8 commit sample old", r, 16'hA000);
        send(16'h0000, 1'b1, r);
        check("R8 new coef active", r, 16'h1234);

        // R8: low write in the same cycle as a sample stays armed
        wr(1'b0, 8'h00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_byte = 8'h10;
        in_valid = 1'b1; in_sample = 16'h0000; in_bit = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        check("R8 overlap sample", out_sample, 16'h1234);
        send(16'h0000, 1'b1, r);
        check("R8 overlap commit old", r, 16'h1234);
        send(16'h0000, 1'b1, r);
        check("R8 overlap new active", r, 16'h0010);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset out", out_sample, 16'h0000);
        rst_n = 1'b1;
        send(16'h0100, 1'b0, r);
        check("R1 coef cleared", r, 16'h0100);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule